// File: doc/BRIEF.md
# Delta-Sigma Converter Two-Wire Readout Port

This block is the digital, device-side model of the serial output port of a delta-sigma converter. A stub sample source presents a 24-bit two's-complement word on `sample_data`. At the end of every conversion period the block captures that word and pulls its single output pin `rdy_dout` low to announce it. The host then clocks the word out on `sclk`, most significant bit first, over the same pin.

Commands travel over the same two wires. The number of serial-clock pulses the host applies, or how long it holds the clock high, selects the command. A falling edge on the 26th pulse starts a self-calibration. Holding the clock high for long enough after a result has been announced puts the block to sleep. Pulling the clock low again wakes it. If exactly 25 pulses had been seen for the current result, a calibration runs first on wake-up. Every interval is counted in system-clock cycles and set by a parameter, so a simulation can shorten all of them. `sclk` is asynchronous. It passes through a two-flop synchroniser, and a third flop detects its edges, so each host edge takes effect on the third system-clock edge after it occurs.

The controller has five states. CALIBRATE is entered from reset. CONVERT is the first conversion after a calibration or a wake-up. WINDOW is the update interval before a capture. AVAILABLE holds a result that can be read. SLEEP is the idle state. The transitions are:
- CALIBRATE→CONVERT when the calibration timer expires.
- CONVERT→WINDOW when the conversion timer expires.
- WINDOW→AVAILABLE when the window timer expires. The sample is captured on this transition.
- AVAILABLE→WINDOW when the conversion timer expires.
- AVAILABLE→CALIBRATE on the serial-clock fall that ends the 26th pulse.
- AVAILABLE→SLEEP or WINDOW→SLEEP when the high-hold detector fires.
- SLEEP→CONVERT or SLEEP→CALIBRATE on the next serial-clock fall.

Top module: `dsm_readout_port`

## Requirements
- R1: When a result becomes available, `rdy_dout` goes low (0) and stays low until the first synchronised rising edge of `sclk`.
- R2: The k-th rising `sclk` edge (k = 1..24) drives bit 24-k of the captured word onto `rdy_dout`, so the most significant bit comes first. The new bit is visible three system clocks after the host's edge.
- R3: After the 24th rising edge, `rdy_dout` keeps the least significant bit until another rising edge arrives. The 25th rising edge drives it to 1, and it stays 1 until the next result is announced.
- R4: Reset starts a calibration. The falling edge that ends the 26th pulse also starts a calibration. A calibration keeps `rdy_dout` at 1 for CAL_CYC cycles and is followed by a fresh conversion of CONV_CYC cycles. The first result after a calibration is the word present at its capture.
- R5: If `sclk` stays high for SLEEP_CYC consecutive cycles while a result is available, or during the update window that follows it, the block enters sleep. `rdy_dout` stays 1 and no result is announced while the block is asleep.
- R6: A falling `sclk` edge while asleep starts a conversion. The result is announced CONV_CYC cycles after the synchronised edge.
- R7: If exactly 25 rising edges were counted for the current result when sleep was entered, wake-up runs a calibration (CAL_CYC cycles) before the conversion.
- R8: While running undisturbed, a new result is announced every CONV_CYC cycles. `rdy_dout` stays low for CONV_CYC-UPD_CYC of those cycles when the result is not read.
- R9: The last UPD_CYC cycles of each period form the update window. During the window `rdy_dout` is 1, and rising `sclk` edges do not advance the bit shifter.
- R10: The word on `sample_data` is captured at the end of the update window. A result that is never read is replaced by the next one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all intervals are counted in its cycles |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Host serial clock, asynchronous to `clk` |
| sample_data | input | DATA_W | Conversion word from the stub sample source, two's complement |
| rdy_dout | output | 1 | Shared ready-flag and serial data pin |

## Verification
The embedded assertions watch the control skeleton on every cycle:
- the pin is low on the first cycle of each new result;
- the pin is stable unless a shift occurred;
- the shifter is frozen inside the update window;
- every exit from sleep is caused by a synchronised falling edge;
- every calibration hands over to a conversion;
- sleep begins only after a full hold of high cycles.

The exact periods, the window length, the wake-up latencies with and without calibration, the bit order of the shifted word and the overwrite of an unread result depend on timing over many cycles. Only the bench's directed scenarios show these.

// File: rtl/dsm_port_pkg.sv
package dsm_port_pkg;

    typedef enum logic [2:0] {
        ST_CAL   = 3'd0,
        ST_CONV  = 3'd1,
        ST_UPD   = 3'd2,
        ST_AVAIL = 3'd3,
        ST_SLEEP = 3'd4
    } port_state_e;

    function automatic int unsigned max3(input int unsigned a,
                                         input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/dsm_sclk_sync.sv
module dsm_sclk_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_async,
    output logic lvl,
    output logic rise,
    output logic fall
);

    // chain[0..STAGES-1] resynchronise, chain[STAGES] is the edge history flop
    logic [STAGES:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-1:0], sclk_async};
        end
    end

    assign lvl  = chain[STAGES-1];
    assign rise = chain[STAGES-1] & ~chain[STAGES];
    assign fall = ~chain[STAGES-1] & chain[STAGES];

endmodule

// File: rtl/dsm_interval_timer.sv
module dsm_interval_timer #(
    parameter int unsigned W       = 8,
    parameter int unsigned RST_VAL = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= W'(RST_VAL - 1);
        end else if (load) begin
            cnt_q <= load_val - W'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign done = (cnt_q == '0);

    // R8: every interval loaded into the timer lasts at least one cycle
    p_load_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_val != '0));

endmodule

// File: rtl/dsm_hold_detect.sv
module dsm_hold_detect #(
    parameter int unsigned HOLD = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic lvl,
    output logic hit
);

    localparam int unsigned HW = $clog2(HOLD + 1);

    logic [HW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en || !lvl) begin
            cnt_q <= '0;
        end else if (cnt_q != HW'(HOLD)) begin
            cnt_q <= cnt_q + HW'(1);
        end
    end

    assign hit = (cnt_q == HW'(HOLD));

    // R5: the detector only fires after an enabled, high cycle
    p_hit_after_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(en && lvl));

endmodule

// File: rtl/dsm_shift_out.sv
module dsm_shift_out #(
    parameter int unsigned DW = 24
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load,
    input  logic [DW-1:0]                 data,
    input  logic                          shift_en,
    output logic                          pin_bit,
    output logic [$clog2(DW+3)-1:0]       pulses
);

    localparam int unsigned CW   = $clog2(DW + 3);
    localparam int unsigned CMAX = (1 << CW) - 1;

    logic [DW-1:0] shreg_q;
    logic          cur_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
            cur_q   <= 1'b1;
            cnt_q   <= '0;
        end else if (load) begin
            shreg_q <= data;
            cur_q   <= 1'b0;
            cnt_q   <= '0;
        end else if (shift_en) begin
            cur_q   <= shreg_q[DW-1];
            shreg_q <= {shreg_q[DW-2:0], 1'b0};
            if (cnt_q != CW'(CMAX)) begin
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

    always_comb begin
        if (cnt_q == '0) begin
            pin_bit = 1'b0;
        end else if (cnt_q > CW'(DW)) begin
            pin_bit = 1'b1;
        end else begin
            pin_bit = cur_q;
        end
    end

    assign pulses = cnt_q;

    // R2: each accepted edge advances the pulse count by exactly one
    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(shift_en) && !$past(load) && ($past(cnt_q) < CW'(DW + 2)))
        |-> (cnt_q == $past(cnt_q) + CW'(1)));

endmodule

// File: rtl/dsm_readout_port.sv
module dsm_readout_port
    import dsm_port_pkg::*;
#(
    parameter int unsigned DATA_W    = 24,
    parameter int unsigned CONV_CYC  = 163840,
    parameter int unsigned UPD_CYC   = 374,
    parameter int unsigned SLEEP_CYC = 163430,
    parameter int unsigned CAL_CYC   = 349798
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic [DATA_W-1:0] sample_data,
    output logic              rdy_dout
);

    localparam int unsigned TMAX      = max3(CONV_CYC, CAL_CYC, UPD_CYC);
    localparam int unsigned TW        = $clog2(TMAX + 1);
    localparam int unsigned CW        = $clog2(DATA_W + 3);
    localparam int unsigned CAL_CNT   = DATA_W + 2;
    localparam int unsigned WCAL_CNT  = DATA_W + 1;
    localparam int unsigned AVAIL_CYC = CONV_CYC - UPD_CYC;

    port_state_e   st_q, st_d;
    logic          s_lvl, s_rise, s_fall;
    logic          tmr_load, tmr_done;
    logic [TW-1:0] tmr_val;
    logic          sh_load, sh_en, sh_bit;
    logic [CW-1:0] sh_cnt;
    logic          hold_en, hold_hit;
    logic          seen_q, wake_cal_q;

    dsm_sclk_sync #(.STAGES(2)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_async (sclk),
        .lvl        (s_lvl),
        .rise       (s_rise),
        .fall       (s_fall)
    );

    dsm_interval_timer #(.W(TW), .RST_VAL(CAL_CYC)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    dsm_shift_out #(.DW(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sh_load),
        .data     (sample_data),
        .shift_en (sh_en),
        .pin_bit  (sh_bit),
        .pulses   (sh_cnt)
    );

    dsm_hold_detect #(.HOLD(SLEEP_CYC)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (hold_en),
        .lvl   (s_lvl),
        .hit   (hold_hit)
    );

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_CAL: begin
                if (tmr_done) st_d = ST_CONV;
            end
            ST_CONV: begin
                if (tmr_done) st_d = ST_UPD;
            end
            ST_UPD: begin
                if (hold_hit)      st_d = ST_SLEEP;
                else if (tmr_done) st_d = ST_AVAIL;
            end
            ST_AVAIL: begin
                if (hold_hit)                               st_d = ST_SLEEP;
                else if (s_fall && sh_cnt >= CW'(CAL_CNT))  st_d = ST_CAL;
                else if (tmr_done)                          st_d = ST_UPD;
            end
            ST_SLEEP: begin
                if (s_fall) st_d = wake_cal_q ? ST_CAL : ST_CONV;
            end
            default: st_d = ST_CAL;
        endcase
    end

    // timer reload on every state change, value chosen by the state entered
    always_comb begin
        tmr_load = (st_d != st_q);
        unique case (st_d)
            ST_CAL:   tmr_val = TW'(CAL_CYC);
            ST_CONV:  tmr_val = TW'(AVAIL_CYC);
            ST_UPD:   tmr_val = TW'(UPD_CYC);
            ST_AVAIL: tmr_val = TW'(AVAIL_CYC);
            ST_SLEEP: tmr_val = TW'(1);
            default:  tmr_val = TW'(1);
        endcase
    end

    assign sh_load = (st_d == ST_AVAIL) && (st_q != ST_AVAIL);
    assign sh_en   = (st_q == ST_AVAIL) && s_rise;
    assign hold_en = (st_q == ST_AVAIL) || ((st_q == ST_UPD) && seen_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= ST_CAL;
            seen_q     <= 1'b0;
            wake_cal_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (st_d == ST_AVAIL) begin
                seen_q <= 1'b1;
            end else if (st_d == ST_CAL || st_d == ST_CONV || st_d == ST_SLEEP) begin
                seen_q <= 1'b0;
            end
            if (st_d == ST_SLEEP && st_q != ST_SLEEP) begin
                wake_cal_q <= (sh_cnt == CW'(WCAL_CNT));
            end
        end
    end

    // output logic
    always_comb begin
        unique case (st_q)
            ST_AVAIL: rdy_dout = sh_bit;
            ST_CAL,
            ST_CONV,
            ST_UPD,
            ST_SLEEP: rdy_dout = 1'b1;
            default:  rdy_dout = 1'b1;
        endcase
    end

    // R1: first cycle of a new result shows the pin low
    p_ready_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_AVAIL && $past(st_q) != ST_AVAIL) |-> !rdy_dout);

    // R3: inside a result the pin only moves after an accepted edge
    p_hold_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_AVAIL && $past(st_q) == ST_AVAIL && !$past(s_rise))
        |-> $stable(rdy_dout));

    // R4: a calibration always hands over to a fresh conversion
    p_cal_then_conv_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st_q) == ST_CAL && st_q != ST_CAL) |-> (st_q == ST_CONV));

    // R5: sleep keeps the pin high from one cycle to the next
    p_sleep_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SLEEP && $past(st_q) == ST_SLEEP) |-> (rdy_dout && $past(rdy_dout)));

    // R6: leaving sleep needs a synchronised falling edge and starts work
    p_wake_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st_q) == ST_SLEEP && st_q != ST_SLEEP)
        |-> ($past(s_fall) && (st_q == ST_CONV || st_q == ST_CAL)));

    // R9: the shifter is frozen during the update window
    p_window_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_UPD && $past(st_q) == ST_UPD) |-> $stable(sh_cnt));

endmodule

// File: tb/dsm_readout_port_test.sv
`timescale 1ns/1ps
module dsm_readout_port_test;

    localparam int unsigned DW    = 24;
    localparam int unsigned CONV  = 400;
    localparam int unsigned UPD   = 10;
    localparam int unsigned SLEEP = 100;
    localparam int unsigned CAL   = 60;
    localparam int          LIMIT = 5000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sclk = 1'b0;
    logic [DW-1:0] sample_data = 24'h800001;
    logic          rdy_dout;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    dsm_readout_port #(
        .DATA_W(DW), .CONV_CYC(CONV), .UPD_CYC(UPD),
        .SLEEP_CYC(SLEEP), .CAL_CYC(CAL)
    ) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk        (sclk),
        .sample_data (sample_data),
        .rdy_dout    (rdy_dout)
    );

    task automatic chk(input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic chk_rng(input string req, input string what,
                           input longint act, input longint lo, input longint hi);
        checks++;
        if (act < lo || act > hi) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, act, lo, hi);
        end
    endtask

    task automatic wait_level(input logic lv, output int n);
        bit got = 1'b0;
        n = 0;
        while (!got && n < LIMIT) begin
            @(negedge clk);
            n++;
            if (rdy_dout === lv) got = 1'b1;
        end
        if (!got) n = -1;
    endtask

    task automatic next_ready();
        int n;
        wait_level(1'b1, n);
        wait_level(1'b0, n);
    endtask

    task automatic pulse(output logic b);
        sclk = 1'b1;
        repeat (4) @(negedge clk);
        b = rdy_dout;
        sclk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic read_word(output logic [DW-1:0] w);
        logic b;
        for (int i = DW - 1; i >= 0; i--) begin
            pulse(b);
            w[i] = b;
        end
    endtask

    task automatic test_reset();
        int n;
        repeat (3) @(negedge clk);
        chk("R4", "pin during reset", rdy_dout, 1);
        rst_n = 1'b1;
        wait_level(1'b0, n);
        chk_rng("R4", "first result after reset calibration", n, CAL + CONV - 3, CAL + CONV + 3);
    endtask

    task automatic test_read();
        logic [DW-1:0] w;
        logic b;
        int n;
        sample_data = 24'h7FFFFF;
        repeat (20) @(negedge clk);
        chk("R1", "pin low before first edge", rdy_dout, 0);
        read_word(w);
        chk("R2", "word 800001 shifted msb first", w, 24'h800001);
        repeat (20) @(negedge clk);
        chk("R3", "pin holds lsb", rdy_dout, 1);
        pulse(b);
        chk("R3", "25th edge forces high", b, 1);
        wait_level(1'b0, n);
        chk("R3", "high until next result", (n > 0) ? 1 : 0, 1);
    endtask

    task automatic test_period();
        int lo_n = 1;
        int hi_n = 1;
        logic [DW-1:0] w;
        sample_data = 24'h000000;
        while (rdy_dout === 1'b0) begin
            @(negedge clk);
            if (rdy_dout === 1'b0) lo_n++;
        end
        while (rdy_dout === 1'b1) begin
            @(negedge clk);
            if (rdy_dout === 1'b1) hi_n++;
        end
        chk("R8", "unread low length", lo_n, CONV - UPD);
        chk("R9", "update window length", hi_n, UPD);
        sample_data = 24'hFFFFFF;
        read_word(w);
        chk("R10", "word 000000", w, 24'h000000);
    endtask

    task automatic test_window_ignore();
        int n;
        logic [DW-1:0] w;
        // current result is all zeros except we read it: pin holds lsb 0
        wait_level(1'b1, n);
        sclk = 1'b1;
        repeat (2) @(negedge clk);
        sclk = 1'b0;
        repeat (2) @(negedge clk);
        wait_level(1'b0, n);
        repeat (6) @(negedge clk);
        chk("R9", "window edge ignored, pin still low", rdy_dout, 0);
        read_word(w);
        chk("R9", "word FFFFFF intact after window edge", w, 24'hFFFFFF);
    endtask

    task automatic test_overwrite();
        logic [DW-1:0] w;
        sample_data = 24'h123456;
        next_ready();
        sample_data = 24'hA5C35A;
        next_ready();
        read_word(w);
        chk("R10", "unread result overwritten", w, 24'hA5C35A);
    endtask

    task automatic test_cal();
        logic [DW-1:0] w;
        logic b;
        int n;
        sample_data = 24'h00FF00;
        next_ready();
        sample_data = 24'h5A5A5A;
        read_word(w);
        chk("R2", "word 00FF00", w, 24'h00FF00);
        pulse(b);
        sclk = 1'b1;
        repeat (4) @(negedge clk);
        sclk = 1'b0;
        wait_level(1'b0, n);
        chk_rng("R4", "26th pulse calibration latency", n, CAL + CONV + 2, CAL + CONV + 4);
        read_word(w);
        chk("R4", "first result after calibration", w, 24'h5A5A5A);
    endtask

    task automatic test_sleep();
        logic [DW-1:0] w;
        int n;
        int lows = 0;
        sample_data = 24'hC0FFEE;
        next_ready();
        sample_data = 24'h0F0F0F;
        sclk = 1'b1;
        repeat (SLEEP + 10) @(negedge clk);
        chk("R5", "pin high after sleep entry", rdy_dout, 1);
        for (int i = 0; i < 2 * CONV; i++) begin
            @(negedge clk);
            if (rdy_dout !== 1'b1) lows++;
        end
        chk("R5", "no result while asleep", lows, 0);
        sclk = 1'b0;
        wait_level(1'b0, n);
        chk_rng("R6", "wake latency", n, CONV + 2, CONV + 4);
        read_word(w);
        chk("R6", "result after wake", w, 24'h0F0F0F);
    endtask

    task automatic test_sleep_cal();
        logic [DW-1:0] w;
        int n;
        sample_data = 24'hABCDEF;
        next_ready();
        sample_data = 24'h3C3C3C;
        read_word(w);
        chk("R2", "word ABCDEF", w, 24'hABCDEF);
        sclk = 1'b1;
        repeat (SLEEP + CONV) @(negedge clk);
        chk("R7", "asleep after 25th edge held", rdy_dout, 1);
        sclk = 1'b0;
        wait_level(1'b0, n);
        chk_rng("R7", "wake with calibration latency", n, CAL + CONV + 2, CAL + CONV + 4);
        read_word(w);
        chk("R7", "result after wake calibration", w, 24'h3C3C3C);
    endtask

    initial begin
        test_reset();
        test_read();
        test_period();
        test_window_ignore();
        test_overwrite();
        test_cal();
        test_sleep();
        test_sleep_cal();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R8 watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule